// File: doc/BRIEF.md
# Motion-Sensor Power Mode Controller

This block decides how often a low-power motion sensor looks for movement. It keeps the sensor in a fully responsive run mode while motion keeps arriving. As idle time grows, it walks the sensor down through three rest levels. Each rest level polls less often than the one above it, so the sensor uses less power the longer it sits still. Every poll raises a one-cycle sample request toward the imaging logic. At the same clock edge it starts a short light-source enable window. The light source is therefore only lit while a sample is being taken.

All time is measured in ticks of a `tick_i` input that the surrounding sampling logic supplies. Every polling period and every per-level dwell timeout is a parameter counted in those ticks. A testbench can shrink them to a few ticks each. A `motion_i` report from the motion computation returns the block to run mode at once and restarts all idle timing. The current level is visible on `mode_o`.

Top module: `pmc_power_mode_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `mode_o` is 0, `sample_req_o` is 0 and `light_en_o` is 0.
- R2: In run mode, each tick without motion that does not cause a downshift raises `sample_req_o` for exactly the one cycle that follows the tick.
- R3: Mode encoding is 0 = run, 1 = rest 1, 2 = rest 2, 3 = rest 3. Without motion, the block moves one level deeper on the RUN_TMO-th tick spent in run, the REST1_TMO-th tick spent in rest 1 and the REST2_TMO-th tick spent in rest 2. The new `mode_o` appears in the cycle after that tick, and a tick that causes a downshift issues no sample request.
- R4: In rest 1, rest 2 and rest 3, a sample request follows every REST1_PER-th, REST2_PER-th and REST3_PER-th tick respectively, counted from entry into that level.
- R5: Rest 3 is terminal: without motion the block stays in mode 3 indefinitely and keeps polling every REST3_PER ticks.
- R6: A clock cycle with `motion_i` high, with or without a tick, puts `mode_o` at 0 in the next cycle and issues no sample request for that cycle. It also clears all idle timing, so the next tick counts as the first idle tick.
- R7: A cycle with neither `tick_i` nor `motion_i` changes no mode and produces no sample request.
- R8: `light_en_o` rises only together with `sample_req_o`, and after a request it stays high for exactly LIGHT_CYC cycles, provided no further request arrives in that window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle timebase strobe; all periods and timeouts count these |
| motion_i | input | 1 | Motion reported by the motion computation |
| mode_o | output | 2 | Current level: 0 run, 1..3 rest 1..3 |
| sample_req_o | output | 1 | One-cycle strobe requesting a motion check |
| light_en_o | output | 1 | Light-source pulse enable, LIGHT_CYC cycles per request |

## Verification
The bound checker watches the rules that hold in every cycle:
- motion forces run mode on the next cycle;
- the mode only ever steps one level deeper or jumps back to run;
- rest 3 never leaves on its own;
- a cycle without a tick never produces a request or a mode change;
- the light window always starts with a request and lasts exactly LIGHT_CYC cycles.

Which tick triggers each downshift, and which ticks poll within each level, depend on counting over long idle stretches. Only the bench shows these. It sweeps every idle length from zero through past rest 3 entry, breaks each one with motion (with and without a coincident tick), and compares every tick against positions it computes arithmetically from the parameters.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_REST1 = 2'd1,
    MODE_REST2 = 2'd2,
    MODE_REST3 = 2'd3
  } pmc_mode_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic pmc_mode_e deeper(input pmc_mode_e m);
    case (m)
      MODE_RUN:   return MODE_REST1;
      MODE_REST1: return MODE_REST2;
      default:    return MODE_REST3;
    endcase
  endfunction

endpackage

// File: rtl/pmc_interval_cnt.sv
module pmc_interval_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         step,
  input  logic [W-1:0] limit,
  output logic         hit
);

  logic [W-1:0] cnt_q;

  // hit marks the step that completes the current interval
  assign hit = step && (cnt_q == (limit - W'(1)));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= hit ? '0 : cnt_q + W'(1);
    end
  end

endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
  import pmc_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int RUN_TMO   = 4,
  parameter int REST1_PER = 2,
  parameter int REST1_TMO = 7,
  parameter int REST2_PER = 3,
  parameter int REST2_TMO = 10,
  parameter int REST3_PER = 5
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      tick,
  input  logic      motion,
  output pmc_mode_e mode,
  output logic      sample_req,
  output logic      sample_fire
);

  pmc_mode_e        mode_q;
  logic             sample_q;
  logic [CNT_W-1:0] dwell_lim;
  logic [CNT_W-1:0] poll_lim;
  logic             dwell_hit;
  logic             poll_hit;
  logic             idle_step;
  logic             downshift;

  // per-level interval selection
  always_comb begin
    case (mode_q)
      MODE_RUN: begin
        poll_lim  = CNT_W'(1);
        dwell_lim = CNT_W'(RUN_TMO);
      end
      MODE_REST1: begin
        poll_lim  = CNT_W'(REST1_PER);
        dwell_lim = CNT_W'(REST1_TMO);
      end
      MODE_REST2: begin
        poll_lim  = CNT_W'(REST2_PER);
        dwell_lim = CNT_W'(REST2_TMO);
      end
      default: begin
        poll_lim  = CNT_W'(REST3_PER);
        dwell_lim = CNT_W'(1);
      end
    endcase
  end

  assign idle_step   = tick && !motion;
  assign downshift   = dwell_hit && (mode_q != MODE_REST3);
  assign sample_fire = poll_hit && !downshift;

  pmc_interval_cnt #(.W(CNT_W)) u_dwell (
    .clk   (clk),
    .rst   (rst),
    .clr   (motion),
    .step  (idle_step),
    .limit (dwell_lim),
    .hit   (dwell_hit)
  );

  pmc_interval_cnt #(.W(CNT_W)) u_poll (
    .clk   (clk),
    .rst   (rst),
    .clr   (motion || downshift),
    .step  (idle_step),
    .limit (poll_lim),
    .hit   (poll_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= MODE_RUN;
      sample_q <= 1'b0;
    end else begin
      sample_q <= sample_fire;
      if (motion) begin
        mode_q <= MODE_RUN;
      end else if (downshift) begin
        mode_q <= deeper(mode_q);
      end
    end
  end

  assign mode       = mode_q;
  assign sample_req = sample_q;

endmodule

// File: rtl/pmc_light_pulse.sv
module pmc_light_pulse #(
  parameter int LIGHT_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic light_en
);

  logic light_q;

  generate
    if (LIGHT_CYC <= 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) light_q <= 1'b0;
        else     light_q <= fire;
      end
    end else begin : g_stretch
      localparam int LW = $clog2(LIGHT_CYC);
      logic [LW-1:0] left_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          light_q <= 1'b0;
          left_q  <= '0;
        end else if (fire) begin
          light_q <= 1'b1;
          left_q  <= LW'(LIGHT_CYC - 1);
        end else if (left_q != '0) begin
          left_q  <= left_q - LW'(1);
        end else begin
          light_q <= 1'b0;
        end
      end
    end
  endgenerate

  assign light_en = light_q;

endmodule

// File: rtl/pmc_power_mode_ctrl.sv
module pmc_power_mode_ctrl #(
  parameter int RUN_TMO   = 500,
  parameter int REST1_PER = 14,
  parameter int REST1_TMO = 6500,
  parameter int REST2_PER = 68,
  parameter int REST2_TMO = 403000,
  parameter int REST3_PER = 340,
  parameter int LIGHT_CYC = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_i,
  input  logic       motion_i,
  output logic [1:0] mode_o,
  output logic       sample_req_o,
  output logic       light_en_o
);

  import pmc_pkg::*;

  localparam int MAX_A   = max_int(RUN_TMO, REST1_TMO);
  localparam int MAX_B   = max_int(REST2_TMO, REST1_PER);
  localparam int MAX_C   = max_int(REST2_PER, REST3_PER);
  localparam int MAX_LIM = max_int(max_int(MAX_A, MAX_B), MAX_C);
  localparam int CNT_W   = $clog2(MAX_LIM + 1);

  pmc_mode_e mode;
  logic      fire;

  pmc_mode_fsm #(
    .CNT_W     (CNT_W),
    .RUN_TMO   (RUN_TMO),
    .REST1_PER (REST1_PER),
    .REST1_TMO (REST1_TMO),
    .REST2_PER (REST2_PER),
    .REST2_TMO (REST2_TMO),
    .REST3_PER (REST3_PER)
  ) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick_i),
    .motion      (motion_i),
    .mode        (mode),
    .sample_req  (sample_req_o),
    .sample_fire (fire)
  );

  pmc_light_pulse #(.LIGHT_CYC(LIGHT_CYC)) u_light (
    .clk      (clk),
    .rst      (rst),
    .fire     (fire),
    .light_en (light_en_o)
  );

  assign mode_o = mode;

endmodule

// File: rtl/pmc_checker.sv
module pmc_checker #(
  parameter int LIGHT_CYC = 4
) (
  input logic       clk,
  input logic       rst,
  input logic       tick_i,
  input logic       motion_i,
  input logic [1:0] mode_o,
  input logic       sample_req_o,
  input logic       light_en_o
);

  // cycles since the last request during which the light has stayed on
  logic [31:0] lit_q;

  always_ff @(posedge clk) begin
    if (rst)               lit_q <= '0;
    else if (sample_req_o) lit_q <= 32'd1;
    else if (light_en_o)   lit_q <= lit_q + 32'd1;
    else                   lit_q <= '0;
  end

  AST_MOTION_TO_RUN: assert property (@(posedge clk) disable iff (rst) motion_i |=> (mode_o == 2'd0)); // R6
  AST_ONE_STEP_DOWN: assert property (@(posedge clk) disable iff (rst) (mode_o != 2'd0 && mode_o != $past(mode_o)) |-> (mode_o == $past(mode_o) + 2'd1)); // R3
  AST_REST3_HOLDS: assert property (@(posedge clk) disable iff (rst) (mode_o == 2'd3 && !motion_i) |=> (mode_o == 2'd3)); // R5
  AST_NO_TICK_NO_SAMPLE: assert property (@(posedge clk) disable iff (rst) (!tick_i || motion_i) |=> !sample_req_o); // R7
  AST_NO_TICK_MODE_STABLE: assert property (@(posedge clk) disable iff (rst) (!tick_i && !motion_i) |=> $stable(mode_o)); // R7
  AST_LIGHT_STARTS_WITH_SAMPLE: assert property (@(posedge clk) disable iff (rst) $rose(light_en_o) |-> sample_req_o); // R8
  AST_SAMPLE_LIGHTS: assert property (@(posedge clk) disable iff (rst) sample_req_o |-> light_en_o); // R8
  AST_LIGHT_HELD: assert property (@(posedge clk) disable iff (rst) (lit_q != 32'd0 && lit_q < 32'(LIGHT_CYC) && !sample_req_o) |-> light_en_o); // R8
  AST_LIGHT_BOUNDED: assert property (@(posedge clk) disable iff (rst) (light_en_o && !sample_req_o) |-> (lit_q < 32'(LIGHT_CYC))); // R8

endmodule

bind pmc_power_mode_ctrl pmc_checker #(.LIGHT_CYC(LIGHT_CYC)) u_pmc_checker (
  .clk          (clk),
  .rst          (rst),
  .tick_i       (tick_i),
  .motion_i     (motion_i),
  .mode_o       (mode_o),
  .sample_req_o (sample_req_o),
  .light_en_o   (light_en_o)
);

// File: tb/tb_pmc_power_mode_ctrl.sv
module tb_pmc_power_mode_ctrl;

  localparam int T0  = 4;
  localparam int P1  = 2;
  localparam int T1  = 7;
  localparam int P2  = 3;
  localparam int T2  = 10;
  localparam int P3  = 5;
  localparam int L   = 2;
  localparam int GAP = 4;
  localparam int B0  = T0;
  localparam int B1  = T0 + T1;
  localparam int B2  = T0 + T1 + T2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_i = 1'b0;
  logic       motion_i = 1'b0;
  logic [1:0] mode_o;
  logic       sample_req_o;
  logic       light_en_o;

  int n_chk = 0;
  int n_err = 0;
  int t_idle = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pmc_power_mode_ctrl #(
    .RUN_TMO(T0), .REST1_PER(P1), .REST1_TMO(T1),
    .REST2_PER(P2), .REST2_TMO(T2), .REST3_PER(P3), .LIGHT_CYC(L)
  ) dut (
    .clk(clk), .rst(rst), .tick_i(tick_i), .motion_i(motion_i),
    .mode_o(mode_o), .sample_req_o(sample_req_o), .light_en_o(light_en_o)
  );

  function automatic int exp_mode(input int t);
    if (t < B0) return 0;
    if (t < B1) return 1;
    if (t < B2) return 2;
    return 3;
  endfunction

  function automatic bit exp_samp(input int t);
    if (t == 0)  return 1'b0;
    if (t < B0)  return 1'b1;
    if (t == B0) return 1'b0;
    if (t < B1)  return ((t - B0) % P1) == 0;
    if (t == B1) return 1'b0;
    if (t < B2)  return ((t - B1) % P2) == 0;
    if (t == B2) return 1'b0;
    return ((t - B2) % P3) == 0;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d (idle ticks %0d)", req, what, act, exp, t_idle);
    end
  endtask

  // one stimulus cycle, then GAP-1 quiet cycles, checking every cycle
  task automatic step(input bit tk, input bit mo);
    int em;
    bit es;
    string rm;
    string rs;
    @(negedge clk);
    tick_i = tk;
    motion_i = mo;
    @(negedge clk);
    tick_i = 1'b0;
    motion_i = 1'b0;
    if (mo) t_idle = 0;
    else if (tk) t_idle++;
    em = exp_mode(t_idle);
    es = (!mo && tk) ? exp_samp(t_idle) : 1'b0;
    rm = mo ? "R6" : (t_idle > B2 ? "R5" : "R3");
    rs = mo ? "R6" : (t_idle < B0 ? "R2" : "R4");
    chk(rm, "mode", int'(mode_o), em);
    chk(rs, "sample_req", int'(sample_req_o), int'(es));
    chk("R8", "light_en at request", int'(light_en_o), int'(es));
    for (int g = 1; g < GAP; g++) begin
      @(negedge clk);
      chk("R7", "quiet mode", int'(mode_o), em);
      chk("R7", "quiet sample_req", int'(sample_req_o), 0);
      chk("R8", "light_en window", int'(light_en_o), int'(es && (g < L)));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset mode", int'(mode_o), 0);
    chk("R1", "reset sample_req", int'(sample_req_o), 0);
    chk("R1", "reset light_en", int'(light_en_o), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "post-reset mode", int'(mode_o), 0);
    chk("R1", "post-reset light_en", int'(light_en_o), 0);
    // every idle length up to past rest 3 entry, broken by motion
    for (int stop = 0; stop <= B2 + 2 * P3; stop++) begin
      for (int k = 0; k < stop; k++) step(1'b1, 1'b0);
      step(stop % 2 == 0, 1'b1);
      step(1'b1, 1'b0);
      step(1'b0, 1'b1);
    end
    // long stay in the terminal level
    for (int k = 0; k < B2 + 12 * P3; k++) step(1'b1, 1'b0);
    chk("R5", "terminal mode", int'(mode_o), 3);
    step(1'b0, 1'b1);
    chk("R6", "motion exits rest 3", int'(mode_o), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule